// File: doc/BRIEF.md
# Single-Cycle Integer RISC Core

This block is a 32-bit load-store processor that completes one instruction per clock. Each cycle it reads a word from an internal instruction array at the current program counter, decodes the fixed-width instruction, reads up to two operands from a 32-entry register file, computes a result, and on the rising edge commits the register write, the data-array store and the new program counter. It covers a small integer subset: register add, subtract and signed set-less-than, the immediate forms of add, OR and set-less-than, load-upper-immediate, word load and store, equal and not-equal branches, absolute jump, jump-and-link and jump-through-register.

The instruction and data arrays live inside the core. A testbench or a loader fills the instruction array before reset is released. The only inputs are the clock and a synchronous reset. The core has no streaming interface, so there is no valid/ready pairing and no back-pressure: it never stalls. The outputs are plain monitors of what the core commits on the coming edge: the program counter, the register write (enable, index, value) and the data store (enable, byte address, value).

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0. While `rst` is high, no register write and no store is reported or committed.
- R2: Any instruction that is not a taken branch or a jump advances the program counter by 4. Instruction words are fetched from word index `pc[7:2]`.
- R3: Opcode field bits 31:26 = 0 selects the function in bits 5:0. Function 32 writes rs+rt and function 34 writes rs-rt to rd. The fields are rs = bits 25:21, rt = 20:16 and rd = 15:11.
- R4: Function 42 (opcode 0) writes 1 to rd when rs < rt as signed values, and 0 otherwise. Opcode 10 does the same comparison against the sign-extended 16-bit immediate in bits 15:0 and writes the result to rt.
- R5: Opcode 8 writes rs plus the sign-extended immediate to rt. Opcode 13 writes rs OR the zero-extended immediate to rt.
- R6: Opcode 15 writes the immediate to rt bits 31:16 and clears bits 15:0.
- R7: Opcode 43 stores rt to the byte address rs + sign-extended immediate, word index = address bits 7:2. Opcode 35 loads the word at that address into rt. A load issued after a store returns the stored value.
- R8: Opcode 4 (rs equal to rt) and opcode 5 (rs not equal to rt) branch when the condition holds. The target is PC+4 plus the sign-extended immediate shifted left by 2, and forward and backward offsets both work. When the condition fails, the next PC is PC+4.
- R9: Opcode 2 jumps to {PC+4 bits 31:28, instruction bits 25:0, 2'b00}. Opcode 3 does the same and also writes PC+4 to register 31.
- R10: Opcode 0 with function 8 sets the program counter to the value of rs.
- R11: Register 0 always reads as zero. A write addressed to it is dropped and not reported on `wb_en_o`.
- R12: An unknown opcode, or opcode 0 with an unknown function, writes nothing, stores nothing and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| pc_o | output | 32 | Address of the instruction executing this cycle |
| wb_en_o | output | 1 | A register write commits at the coming edge |
| wb_addr_o | output | 5 | Register index being written |
| wb_data_o | output | 32 | Value being written |
| st_en_o | output | 1 | A data store commits at the coming edge |
| st_addr_o | output | 32 | Byte address of the store |
| st_data_o | output | 32 | Word being stored |

## Verification
The core runs a preloaded program. In every cycle, the next PC, the register write and the store are compared with a behavioural instruction-level model. Operand pairs mix positive and negative values, so signed comparison is distinguished from unsigned and sign extension from zero extension (an immediate with bit 15 set is used with both OR and add). The program stores a word and loads it back with negative and positive displacements. It uses a branch that is not taken, forward and backward taken branches, a counted loop, a call with link and return, a self-jump, undefined encodings and writes to register 0. A reset in the middle of the run checks that the PC restarts while register and memory contents carry over.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN   = 32;
  localparam int RAW    = 5;
  localparam int NREGS  = 1 << RAW;
  localparam logic [RAW-1:0] LINK_REG = 5'd31;

  localparam logic [5:0] OP_SPECIAL = 6'd0;
  localparam logic [5:0] OP_J       = 6'd2;
  localparam logic [5:0] OP_JAL     = 6'd3;
  localparam logic [5:0] OP_BEQ     = 6'd4;
  localparam logic [5:0] OP_BNE     = 6'd5;
  localparam logic [5:0] OP_ADDI    = 6'd8;
  localparam logic [5:0] OP_SLTI    = 6'd10;
  localparam logic [5:0] OP_ORI     = 6'd13;
  localparam logic [5:0] OP_LUI     = 6'd15;
  localparam logic [5:0] OP_LW      = 6'd35;
  localparam logic [5:0] OP_SW      = 6'd43;

  localparam logic [5:0] FN_JR  = 6'd8;
  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_SLT, ALU_OR, ALU_PASSB} alu_op_e;
  typedef enum logic [1:0] {OPB_REG, OPB_SEXT, OPB_ZEXT, OPB_HIGH} opb_sel_e;
  typedef enum logic [1:0] {DST_NONE, DST_RD, DST_RT, DST_LINK} dst_sel_e;
  typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_LINK} wb_sel_e;

  typedef struct packed {
    dst_sel_e dst;
    wb_sel_e  wb;
    opb_sel_e opb;
    alu_op_e  alu;
    logic     mem_we;
    logic     br_eq;
    logic     br_ne;
    logic     jump;
    logic     jump_reg;
  } ctrl_t;
endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
  import sc_pkg::*;
(
  input  logic [5:0] op_i,
  input  logic [5:0] fn_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o     = '0;
    ctrl_o.dst = DST_NONE;
    ctrl_o.wb  = WB_ALU;
    ctrl_o.opb = OPB_REG;
    ctrl_o.alu = ALU_ADD;
    case (op_i)
      OP_SPECIAL: begin
        case (fn_i)
          FN_ADD: ctrl_o.dst = DST_RD;
          FN_SUB: begin ctrl_o.dst = DST_RD; ctrl_o.alu = ALU_SUB; end
          FN_SLT: begin ctrl_o.dst = DST_RD; ctrl_o.alu = ALU_SLT; end
          FN_JR:  ctrl_o.jump_reg = 1'b1;
          default: ;  // unknown function: no-op (R12)
        endcase
      end
      OP_ADDI: begin ctrl_o.dst = DST_RT; ctrl_o.opb = OPB_SEXT; end
      OP_SLTI: begin ctrl_o.dst = DST_RT; ctrl_o.opb = OPB_SEXT; ctrl_o.alu = ALU_SLT; end
      OP_ORI:  begin ctrl_o.dst = DST_RT; ctrl_o.opb = OPB_ZEXT; ctrl_o.alu = ALU_OR; end
      OP_LUI:  begin ctrl_o.dst = DST_RT; ctrl_o.opb = OPB_HIGH; ctrl_o.alu = ALU_PASSB; end
      OP_LW:   begin ctrl_o.dst = DST_RT; ctrl_o.opb = OPB_SEXT; ctrl_o.wb = WB_MEM; end
      OP_SW:   begin ctrl_o.opb = OPB_SEXT; ctrl_o.mem_we = 1'b1; end
      OP_BEQ:  ctrl_o.br_eq = 1'b1;
      OP_BNE:  ctrl_o.br_ne = 1'b1;
      OP_J:    ctrl_o.jump = 1'b1;
      OP_JAL:  begin ctrl_o.jump = 1'b1; ctrl_o.dst = DST_LINK; ctrl_o.wb = WB_LINK; end
      default: ;  // unknown opcode: no-op (R12)
    endcase
    // R12: at most one flow-change kind per instruction
    a_r12_one_flow: assert ($onehot0({ctrl_o.br_eq, ctrl_o.br_ne, ctrl_o.jump, ctrl_o.jump_reg}));
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
(
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  alu_op_e         op_i,
  output logic [XLEN-1:0] y_o
);
  always_comb begin
    case (op_i)
      ALU_ADD:   y_o = a_i + b_i;
      ALU_SUB:   y_o = a_i - b_i;
      ALU_SLT:   y_o = ($signed(a_i) < $signed(b_i)) ? {{(XLEN-1){1'b0}}, 1'b1} : '0;
      ALU_OR:    y_o = a_i | b_i;
      ALU_PASSB: y_o = b_i;
      default:   y_o = '0;
    endcase
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int WIDTH = 32,
  parameter int AW    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_a_i,
  input  logic [AW-1:0]    raddr_b_i,
  output logic [WIDTH-1:0] rdata_a_o,
  output logic [WIDTH-1:0] rdata_b_o
);
  localparam int DEPTH = 1 << AW;

  logic [WIDTH-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 1; i < DEPTH; i++) begin
      if (we_i && !rst && waddr_i == AW'(i)) regs[i] <= wdata_i;
    end
  end

  assign rdata_a_o = (raddr_a_i == '0) ? '0 : regs[raddr_a_i];
  assign rdata_b_o = (raddr_b_i == '0) ? '0 : regs[raddr_b_i];

  // R3: a committed write to a nonzero index is held in that entry afterwards
  a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
    (we_i && waddr_i != '0) |=> (regs[$past(waddr_i)] == $past(wdata_i)));
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] pc_o,
  output logic            wb_en_o,
  output logic [RAW-1:0]  wb_addr_o,
  output logic [XLEN-1:0] wb_data_o,
  output logic            st_en_o,
  output logic [XLEN-1:0] st_addr_o,
  output logic [XLEN-1:0] st_data_o
);
  localparam int IA = $clog2(IMEM_WORDS);
  localparam int DA = $clog2(DMEM_WORDS);

  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  initial for (int i = 0; i < IMEM_WORDS; i++) imem[i] = '0;

  logic [XLEN-1:0] pc_q, pc_plus4, br_tgt, jmp_tgt, pc_next;
  logic [XLEN-1:0] instr, rs_val, rt_val, imm_sext, imm_zext, opb, alu_y, mem_rdata;
  logic [RAW-1:0]  dst_addr;
  logic            dst_valid, br_taken, take_flow;
  ctrl_t           ctrl;

  // fetch
  assign instr    = imem[pc_q[IA+1:2]];
  assign pc_plus4 = pc_q + 32'd4;

  sc_decoder u_dec (
    .op_i   (instr[31:26]),
    .fn_i   (instr[5:0]),
    .ctrl_o (ctrl)
  );

  sc_regfile #(.WIDTH(XLEN), .AW(RAW)) u_rf (
    .clk       (clk),
    .rst       (rst),
    .we_i      (wb_en_o),
    .waddr_i   (wb_addr_o),
    .wdata_i   (wb_data_o),
    .raddr_a_i (instr[25:21]),
    .raddr_b_i (instr[20:16]),
    .rdata_a_o (rs_val),
    .rdata_b_o (rt_val)
  );

  // operand B selection
  assign imm_sext = {{16{instr[15]}}, instr[15:0]};
  assign imm_zext = {16'd0, instr[15:0]};
  always_comb begin
    case (ctrl.opb)
      OPB_SEXT: opb = imm_sext;
      OPB_ZEXT: opb = imm_zext;
      OPB_HIGH: opb = {instr[15:0], 16'd0};
      default:  opb = rt_val;
    endcase
  end

  sc_alu u_alu (
    .a_i  (rs_val),
    .b_i  (opb),
    .op_i (ctrl.alu),
    .y_o  (alu_y)
  );

  // data memory
  assign mem_rdata = dmem[alu_y[DA+1:2]];
  always_ff @(posedge clk) begin
    if (st_en_o) dmem[alu_y[DA+1:2]] <= rt_val;
  end
  assign st_en_o   = ctrl.mem_we && !rst;
  assign st_addr_o = alu_y;
  assign st_data_o = rt_val;

  // write-back
  always_comb begin
    dst_valid = 1'b1;
    case (ctrl.dst)
      DST_RD:   dst_addr = instr[15:11];
      DST_RT:   dst_addr = instr[20:16];
      DST_LINK: dst_addr = LINK_REG;
      default:  begin dst_addr = '0; dst_valid = 1'b0; end
    endcase
  end
  always_comb begin
    case (ctrl.wb)
      WB_MEM:  wb_data_o = mem_rdata;
      WB_LINK: wb_data_o = pc_plus4;
      default: wb_data_o = alu_y;
    endcase
  end
  assign wb_addr_o = dst_addr;
  assign wb_en_o   = dst_valid && (dst_addr != '0) && !rst;

  // next PC
  assign br_tgt    = pc_plus4 + {imm_sext[XLEN-3:0], 2'b00};
  assign jmp_tgt   = {pc_plus4[31:28], instr[25:0], 2'b00};
  assign br_taken  = (ctrl.br_eq && (rs_val == rt_val)) || (ctrl.br_ne && (rs_val != rt_val));
  assign take_flow = br_taken || ctrl.jump || ctrl.jump_reg;
  always_comb begin
    if (ctrl.jump_reg)  pc_next = rs_val;
    else if (ctrl.jump) pc_next = jmp_tgt;
    else if (br_taken)  pc_next = br_tgt;
    else                pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end
  assign pc_o = pc_q;

  // R2: sequential instructions step the PC by one word
  a_r2_seq_pc: assert property (@(posedge clk) disable iff (rst)
    !take_flow |=> pc_q == $past(pc_q) + 32'd4);
  // R9: the call writes the return address into the link register
  a_r9_link: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] == OP_JAL) |-> (wb_en_o && wb_addr_o == LINK_REG && wb_data_o == pc_q + 32'd4));
  // R6: upper-immediate results carry a clear lower half
  a_r6_lui_low: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] == OP_LUI && wb_en_o) |-> wb_data_o[15:0] == 16'd0);
  // R7: a store never also writes the register file
  a_r7_store_sole: assert property (@(posedge clk) disable iff (rst)
    st_en_o |-> !wb_en_o);
endmodule

// File: tb/sc_core_bench.sv
module sc_core_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;
  logic rst = 1'b1;

  logic [31:0] pc_o, wb_data_o, st_addr_o, st_data_o;
  logic [4:0]  wb_addr_o;
  logic        wb_en_o, st_en_o;

  sc_core u_sc_core (
    .clk(clk), .rst(rst), .pc_o(pc_o), .wb_en_o(wb_en_o), .wb_addr_o(wb_addr_o),
    .wb_data_o(wb_data_o), .st_en_o(st_en_o), .st_addr_o(st_addr_o), .st_data_o(st_data_o)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fn);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
  endfunction
  function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
    return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] enc_j(int op, int tgt);
    return {op[5:0], tgt[25:0]};
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] prog  [64];
  logic [31:0] m_reg [32];
  logic [31:0] m_mem [64];
  logic [31:0] m_pc;
  string       pc_tag;
  logic        e_we, e_st, e_flow;
  logic [4:0]  e_wa;
  logic [31:0] e_wd, e_sa, e_sd, e_npc;
  string       e_tag;

  task automatic predict();
    logic [31:0] ins, a, b, sx, p4, ea;
    logic [5:0]  op, fn;
    ins = prog[m_pc[7:2]];
    op = ins[31:26]; fn = ins[5:0];
    a  = m_reg[ins[25:21]]; b = m_reg[ins[20:16]];
    sx = {{16{ins[15]}}, ins[15:0]};
    p4 = m_pc + 32'd4;
    ea = a + sx;
    e_we = 0; e_wa = 0; e_wd = 0; e_st = 0; e_sa = 0; e_sd = 0;
    e_npc = p4; e_flow = 0; e_tag = "R12";
    case (op)
      6'd0: case (fn)
        6'd32: begin e_we = 1; e_wa = ins[15:11]; e_wd = a + b; e_tag = "R3"; end
        6'd34: begin e_we = 1; e_wa = ins[15:11]; e_wd = a - b; e_tag = "R3"; end
        6'd42: begin e_we = 1; e_wa = ins[15:11]; e_wd = ($signed(a) < $signed(b)) ? 1 : 0; e_tag = "R4"; end
        6'd8:  begin e_npc = a; e_flow = 1; e_tag = "R10"; end
        default: ;
      endcase
      6'd8:  begin e_we = 1; e_wa = ins[20:16]; e_wd = ea; e_tag = "R5"; end
      6'd10: begin e_we = 1; e_wa = ins[20:16]; e_wd = ($signed(a) < $signed(sx)) ? 1 : 0; e_tag = "R4"; end
      6'd13: begin e_we = 1; e_wa = ins[20:16]; e_wd = a | {16'd0, ins[15:0]}; e_tag = "R5"; end
      6'd15: begin e_we = 1; e_wa = ins[20:16]; e_wd = {ins[15:0], 16'd0}; e_tag = "R6"; end
      6'd35: begin e_we = 1; e_wa = ins[20:16]; e_wd = m_mem[ea[7:2]]; e_tag = "R7"; end
      6'd43: begin e_st = 1; e_sa = ea; e_sd = b; e_tag = "R7"; end
      6'd4:  begin e_flow = 1; e_tag = "R8"; if (a == b) e_npc = p4 + {sx[29:0], 2'b00}; end
      6'd5:  begin e_flow = 1; e_tag = "R8"; if (a != b) e_npc = p4 + {sx[29:0], 2'b00}; end
      6'd2:  begin e_flow = 1; e_tag = "R9"; e_npc = {p4[31:28], ins[25:0], 2'b00}; end
      6'd3:  begin e_flow = 1; e_tag = "R9"; e_npc = {p4[31:28], ins[25:0], 2'b00};
                   e_we = 1; e_wa = 5'd31; e_wd = p4; end
      default: ;
    endcase
    if (op == 6'd0 && e_we && ins[25:21] == 0 && ins[20:16] == 0) e_tag = "R11";
    if (e_we && e_wa == 0) begin e_we = 0; e_tag = "R11"; end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) prog[i] = 32'd0;
    prog[0]  = enc_r(0, 0, 17, 32);
    prog[1]  = enc_i(8, 0, 1, 5);
    prog[2]  = enc_i(8, 0, 2, -3);
    prog[3]  = enc_r(1, 2, 3, 32);
    prog[4]  = enc_r(2, 1, 4, 34);
    prog[5]  = enc_r(2, 1, 5, 42);
    prog[6]  = enc_r(1, 2, 6, 42);
    prog[7]  = enc_i(10, 2, 7, -2);
    prog[8]  = enc_i(13, 0, 8, 'h8001);
    prog[9]  = enc_i(15, 0, 9, 'hABCD);
    prog[10] = enc_i(13, 9, 9, 'h1234);
    prog[11] = enc_i(8, 0, 10, 16);
    prog[12] = enc_i(43, 10, 9, -4);
    prog[13] = enc_i(43, 10, 4, 4);
    prog[14] = enc_i(35, 10, 11, -4);
    prog[15] = enc_i(35, 10, 12, 4);
    prog[16] = enc_i(8, 0, 0, 7);
    prog[17] = enc_r(0, 0, 13, 32);
    prog[18] = enc_i(4, 1, 2, 5);
    prog[19] = enc_i(5, 1, 2, 1);
    prog[20] = enc_i(8, 0, 14, 99);
    prog[21] = enc_i(4, 3, 3, 1);
    prog[22] = enc_i(8, 0, 14, 98);
    prog[23] = 32'hFC00_0000;
    prog[24] = enc_r(1, 2, 15, 63);
    prog[25] = enc_j(3, 31);
    prog[26] = enc_i(8, 0, 16, 1);
    prog[27] = enc_i(8, 17, 17, 1);
    prog[28] = enc_i(10, 17, 18, 3);
    prog[29] = enc_i(5, 18, 0, -3);
    prog[30] = enc_j(2, 30);
    prog[31] = enc_i(8, 0, 19, 'h7fff);
    prog[32] = enc_r(31, 0, 0, 8);
    for (int i = 0; i < 32; i++) m_reg[i] = 32'd0;
    for (int i = 0; i < 64; i++) m_mem[i] = 32'd0;
    m_pc = 32'd0;
    pc_tag = "R1";
    #1;
    for (int i = 0; i < 64; i++) u_sc_core.imem[i] = prog[i];

    for (int cyc = 0; cyc < 110; cyc++) begin
      logic next_rst;
      @(negedge clk);
      predict();
      check(pc_tag, "pc", pc_o, m_pc);
      if (rst) begin
        check("R1", "wb_en during reset", {31'd0, wb_en_o}, 32'd0);
        check("R1", "st_en during reset", {31'd0, st_en_o}, 32'd0);
      end else begin
        check(e_tag, "wb_en", {31'd0, wb_en_o}, {31'd0, e_we});
        if (e_we) begin
          check(e_tag, "wb_addr", {27'd0, wb_addr_o}, {27'd0, e_wa});
          check(e_tag, "wb_data", wb_data_o, e_wd);
        end
        check(e_tag, "st_en", {31'd0, st_en_o}, {31'd0, e_st});
        if (e_st) begin
          check(e_tag, "st_addr", st_addr_o, e_sa);
          check(e_tag, "st_data", st_data_o, e_sd);
        end
      end
      next_rst = (cyc < 4) || (cyc >= 56 && cyc < 59);
      rst = next_rst;
      if (next_rst) begin
        m_pc = 32'd0;
        pc_tag = "R1";
      end else begin
        if (e_we) m_reg[e_wa] = e_wd;
        if (e_st) m_mem[e_sa[7:2]] = e_sd;
        m_pc = e_npc;
        pc_tag = e_flow ? e_tag : "R2";
      end
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R2 watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule